// File: doc/BRIEF.md
# Gated Ring Oscillator Frequency Meter

This block estimates the speed of a free-running on-chip inverter ring by letting it run for a programmed number of system clock cycles and counting how often it toggled. The block drives one enable line that starts and stops the ring. The ring itself sits outside the block. When the enable is low the ring is held in a known quiet state. The raw ring output goes into the block as an asynchronous input. A single toggle flip-flop halves its rate. Only that halved signal clocks a Gray-coded event counter.

The count crosses into the system clock domain only after the ring has been stopped and a settling interval has passed. It then goes through a two-flop synchronizer and an XOR prefix chain that turns Gray code into binary. The result is presented together with a one-cycle done pulse and a wrap flag.

Successive readings are expected to differ by a few percent as supply, temperature and process shift. The block reports each raw count unfiltered, so software can average or compare readings itself.

Top module: `ringFreqMeter`

## Requirements
- R1: While reset is held and after it is released, oscEnable, measDone, measOverflow and measCount are all 0.
- R2: A startPulse sampled high while idle latches windowLen on that same clock edge. oscEnable rises on the second following edge and stays high for exactly windowLen system clock cycles. Later changes of windowLen do not affect the running measurement.
- R3: A windowLen of 0 behaves like 1: oscEnable is high for one cycle.
- R4: measCount equals the number of rising edges of the halved oscillator signal during the window, as unsigned binary. The halving flop toggles on each rising edge of oscIn, starting from 0, so the count is (n+1)/2 for n rising edges of oscIn. The internal counter changes exactly one bit per step.
- R5: measDone is high for exactly one cycle. It rises SETTLE_CYC (at least 4) cycles after oscEnable falls, and oscEnable is low whenever a capture happens. measCount and measOverflow change only with measDone and hold until the next one.
- R6: A startPulse that arrives while a measurement is in progress is ignored. It does not extend, restart or reload the window and causes no extra measDone.
- R7: The counter is CNT_W bits wide (default 24) and wraps modulo 2^CNT_W. measOverflow is 1 exactly when the counter wrapped during that window.
- R8: Each start clears the counter, the halving flop and the wrap flag. Each reading therefore depends only on its own window, and different ring speeds give their own raw counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a measurement when idle |
| windowLen | input | WIN_W | Window length in system clock cycles |
| oscIn | input | 1 | Asynchronous ring oscillator output |
| oscEnable | output | 1 | Common gate for all ring stages |
| measCount | output | CNT_W | Binary count of halved oscillator edges |
| measOverflow | output | 1 | Counter wrapped during the window |
| measDone | output | 1 | One-cycle result-valid strobe |

## Verification
Take the edge that samples startPulse as edge 0. oscEnable is due at edge 2 and falls at edge 2+W, where W is max(windowLen,1). measDone, measCount and measOverflow are due at edge W+SETTLE_CYC+2. The bench drives inputs and samples outputs only on falling clock edges. It indexes each falling edge from the start edge and checks the enable's first high sample, its high-cycle count and the done index against those formulas. It compares the result with (n+1)/2 mod 2^CNT_W, where n is the number of oscillator rising edges its own ring model produced.

// File: rtl/ringMeterPkg.sv
`timescale 1ns/1ps
package ringMeterPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearOsc;  // hold oscillator-domain state in reset
    logic runOsc;    // request the ring enable
    logic capture;   // take the synchronized count
  } meterCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_RUN, ST_SETTLE, ST_CAPTURE
  } meterState_t;

endpackage

// File: rtl/ringMeterCtrl.sv
`timescale 1ns/1ps
module ringMeterCtrl
  import ringMeterPkg::*;
#(
  parameter int WIN_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [WIN_W-1:0] windowLen,
  output meterCtrl_t       strobes
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SETTLE_LOAD = SET_W'(SETTLE_CYC - 1);

  meterState_t      state;
  logic [WIN_W-1:0] winCnt;
  logic [SET_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      winCnt    <= '0;
      settleCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startPulse) begin
          winCnt <= windowLen;
          state  <= ST_CLEAR;
        end
        ST_CLEAR: state <= ST_RUN;
        ST_RUN: begin
          if (winCnt <= WIN_W'(1)) begin
            settleCnt <= SETTLE_LOAD;
            state     <= ST_SETTLE;
          end else begin
            winCnt <= winCnt - 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_CAPTURE;
          else settleCnt <= settleCnt - 1'b1;
        end
        ST_CAPTURE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clearOsc = (state == ST_CLEAR);
    strobes.runOsc   = (state == ST_RUN);
    strobes.capture  = (state == ST_CAPTURE);
  end

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && startPulse && winCnt > WIN_W'(1)) |=> (state == ST_RUN)); // R6

  AST_WINDOW_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && winCnt > WIN_W'(1)) |=> (winCnt == $past(winCnt) - 1'b1)); // R2

endmodule

// File: rtl/ringMeterDatapath.sv
`timescale 1ns/1ps
module ringMeterDatapath
  import ringMeterPkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscIn,
  input  meterCtrl_t       strobes,
  output logic             oscEnable,
  output logic [CNT_W-1:0] measCount,
  output logic             measOverflow,
  output logic             measDone
);
  localparam int MSB = CNT_W - 1;

  // ---------------- system-domain gate and clear flops ----------------
  logic clrQ, enQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrQ <= 1'b0;
      enQ  <= 1'b0;
    end else begin
      clrQ <= strobes.clearOsc;
      enQ  <= strobes.runOsc;
    end
  end
  assign oscEnable = enQ;

  // Oscillator-domain reset: registered, applied only while the ring is stopped
  logic oscRst;
  assign oscRst = clrQ | ~rstN;

  // ---------------- oscillator domain ----------------
  logic divQ;
  always_ff @(posedge oscIn or posedge oscRst) begin
    if (oscRst) divQ <= 1'b0;
    else        divQ <= ~divQ;
  end

  logic [CNT_W-1:0] grayQ, grayPrev, grayNext, binNow, binInc;
  logic             wrapQ;

  // Prefix XOR decode of the live code for the increment path
  genvar gi;
  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_liveDecode
      if (gi == MSB) begin : g_top
        assign binNow[gi] = grayQ[gi];
      end else begin : g_rest
        assign binNow[gi] = binNow[gi+1] ^ grayQ[gi];
      end
    end
  endgenerate

  assign binInc   = binNow + 1'b1;
  assign grayNext = binInc ^ (binInc >> 1);

  always_ff @(posedge divQ or posedge oscRst) begin
    if (oscRst) begin
      grayQ    <= '0;
      grayPrev <= '0;
      wrapQ    <= 1'b0;
    end else begin
      grayPrev <= grayQ;
      grayQ    <= grayNext;
      wrapQ    <= wrapQ | (grayQ[MSB] & ~grayNext[MSB]);
    end
  end

  always_ff @(posedge divQ) begin
    if (!oscRst)
      AST_GRAY_ONE_STEP: assert ($countones(grayQ ^ grayPrev) <= 1); // R4
  end

  // ---------------- synchronizer into the system domain ----------------
  logic [CNT_W-1:0] syncG1, syncG2, binSync;
  logic             syncW1, syncW2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncG1 <= '0; syncG2 <= '0;
      syncW1 <= 1'b0; syncW2 <= 1'b0;
    end else begin
      syncG1 <= grayQ; syncG2 <= syncG1;
      syncW1 <= wrapQ; syncW2 <= syncW1;
    end
  end

  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_syncDecode
      if (gi == MSB) begin : g_top
        assign binSync[gi] = syncG2[gi];
      end else begin : g_rest
        assign binSync[gi] = binSync[gi+1] ^ syncG2[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measCount    <= '0;
      measOverflow <= 1'b0;
      measDone     <= 1'b0;
    end else begin
      measDone <= strobes.capture;
      if (strobes.capture) begin
        measCount    <= binSync;
        measOverflow <= syncW2;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    measDone |=> !measDone); // R5

  AST_RING_STOPPED_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> !enQ); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !measDone |-> $stable(measCount)); // R5

endmodule

// File: rtl/ringFreqMeter.sv
`timescale 1ns/1ps
module ringFreqMeter
  import ringMeterPkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int WIN_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [WIN_W-1:0] windowLen,
  input  logic             oscIn,
  output logic             oscEnable,
  output logic [CNT_W-1:0] measCount,
  output logic             measOverflow,
  output logic             measDone
);
  meterCtrl_t strobes;

  ringMeterCtrl #(.WIN_W(WIN_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .windowLen(windowLen), .strobes(strobes)
  );

  ringMeterDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .strobes(strobes),
    .oscEnable(oscEnable), .measCount(measCount),
    .measOverflow(measOverflow), .measDone(measDone)
  );

endmodule

// File: tb/tb_ringFreqMeter.sv
`timescale 1ns/1ps
module tb_ringFreqMeter;
  localparam int CNT_W  = 10;
  localparam int WIN_W  = 16;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [WIN_W-1:0] windowLen = '0;
  logic oscIn = 1'b0;
  logic oscEnable, measOverflow, measDone;
  logic [CNT_W-1:0] measCount;

  int checks = 0;
  int errors = 0;
  int oscEdges = 0;
  real halfPer = 0.73;

  ringFreqMeter #(.CNT_W(CNT_W), .WIN_W(WIN_W), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .windowLen(windowLen),
    .oscIn(oscIn), .oscEnable(oscEnable), .measCount(measCount),
    .measOverflow(measOverflow), .measDone(measDone)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  // Gated ring model: quiet at 0 when disabled
  always begin
    if (oscEnable !== 1'b1) begin
      oscIn = 1'b0;
      @(posedge oscEnable);
    end
    #(halfPer);
    if (oscEnable === 1'b1) oscIn = ~oscIn;
    else oscIn = 1'b0;
  end

  always @(posedge oscIn) oscEdges++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One measurement; optional extra start injected while busy
  task automatic measure(input int win, input real hp, input bit inject, input string tag);
    int expW, firstEn, enHigh, doneK, k, expCnt;
    bit expOvf;
    logic [CNT_W-1:0] held;
    expW = (win == 0) ? 1 : win;
    halfPer = hp;
    firstEn = -1; enHigh = 0; doneK = -1; k = 0;
    @(negedge clk);
    oscEdges = 0;
    startPulse = 1'b1;
    windowLen = WIN_W'(win);
    @(negedge clk);               // k = 0, start sampled at edge 0
    startPulse = 1'b0;
    windowLen = WIN_W'(3);        // later change must be ignored (R2)
    while (doneK < 0 && k < 20000) begin
      if (oscEnable) begin
        enHigh++;
        if (firstEn < 0) firstEn = k;
      end
      if (measDone) doneK = k;
      if (inject && k == 5) startPulse = 1'b1;
      if (inject && k == 6) startPulse = 1'b0;
      if (doneK < 0) begin
        @(negedge clk);
        k++;
      end
    end
    expCnt = ((oscEdges + 1) / 2) % (1 << CNT_W);
    expOvf = ((oscEdges + 1) / 2) >= (1 << CNT_W);
    check(firstEn == 2, "R2", {tag, " enable rise index"}, firstEn, 2);
    check(enHigh == expW, (win == 0) ? "R3" : (inject ? "R6" : "R2"),
          {tag, " enable high cycles"}, enHigh, expW);
    check(doneK == expW + SETTLE + 2, "R5", {tag, " done index"}, doneK, expW + SETTLE + 2);
    check(measCount == CNT_W'(expCnt), "R4", {tag, " count"}, measCount, expCnt);
    check(measOverflow == expOvf, "R7", {tag, " overflow"}, measOverflow, expOvf);
    held = measCount;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(!measDone, inject ? "R6" : "R5", {tag, " done after pulse"}, measDone, 0);
      check(measCount == held, "R5", {tag, " count held"}, measCount, held);
    end
  endtask

  initial begin
    #750000;
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!oscEnable, "R1", "enable in reset", oscEnable, 0);
    check(!measDone, "R1", "done in reset", measDone, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!oscEnable, "R1", "enable after reset", oscEnable, 0);
    check(measCount == '0, "R1", "count after reset", measCount, 0);
    check(!measOverflow, "R1", "overflow after reset", measOverflow, 0);

    measure(100, 0.73, 1'b0, "basic");      // R2 R4 R5
    measure(0,   0.73, 1'b0, "zero window"); // R3
    measure(1,   0.61, 1'b0, "one window");  // R3
    measure(60,  0.73, 1'b1, "busy start");  // R6
    measure(100, 1.10, 1'b0, "slower ring"); // R8
    measure(800, 0.37, 1'b0, "wrap");        // R7
    measure(550, 0.73, 1'b0, "no wrap");     // R7 R8 flag cleared
    summary();
  end

endmodule